// File: doc/BRIEF.md
# Two-Phase Controller Register Sequencer

This block turns a single register request into the bus cycles a USB host/device controller needs when its registers sit behind indirect port access on a 16-bit asynchronous parallel bus. The controller has two pairs of ports, one pair for its host side and one for its device side. Each pair has a write-only command port that takes a register address and a data port that moves the register contents. Address line A0 picks between data and command port. Address line A1 picks between host and device side. One active-low chip select serves both sides.

A register access first writes the register address to the command port and then makes one data-port transfer for a 16-bit register or two for a 32-bit register. Chip select is held high for a minimum gap before every data phase. The gap is set in picoseconds and converted to clock cycles, rounded up. A direct mode makes one transfer to a chosen port with no command phase. A direct read of a command port is refused: it gets an error flag and the bus stays quiet. Read data comes back with a one-cycle done pulse.

Top module: `hc_reg_seq`

## Requirements
- R1: A register request begins with one write cycle at the command port (A0 = 1) of the selected side, carrying the register address on the data bus.
- R2: A1 equals the side select of the request (0 = host, 1 = device) during every bus cycle of that request, and A0/A1 do not change while chip select is low.
- R3: A 16-bit register request makes exactly one data-port cycle (A0 = 0) after the command cycle, writing req_wdata[15:0] or reading one word.
- R4: A 32-bit register request makes two data-port cycles after the command cycle. The first carries bits 15:0 and the second carries bits 31:16, for both writes and reads.
- R5: Before each data phase of a register request, chip select stays high for exactly GAP_CYC = ceil(CS_GAP_PS / CLK_PERIOD_PS) cycles, which is 38 cycles at the defaults.
- R6: A read or write strobe goes low only while chip select is low, never both at once, and stays low for exactly PULSE_CYC cycles (3 by default).
- R7: The block drives the data bus only while its write strobe is low. At all other times the bus is high-impedance.
- R8: On a read, rdata[15:0] holds the first data word and rdata[31:16] holds the second. A 16-bit read returns zero in rdata[31:16].
- R9: A direct request that reads a command port (req_direct = 1, req_cmdport = 1, req_write = 0) raises err together with done on the cycle after the request and produces no bus cycle.
- R10: busy is high from the cycle after a request is accepted until done. A request presented while busy is ignored and causes no bus cycle.
- R11: After reset, chip select and both strobes are high, and busy, done and err are low. done is a single-cycle pulse.
- R12: A direct request makes exactly one bus cycle at the port given by req_cmdport (A0 = req_cmdport) and has no command phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_direct | input | 1 | 1 = single transfer to one port, 0 = register access |
| req_cmdport | input | 1 | Direct mode: 1 = command port, 0 = data port |
| req_dev | input | 1 | Side select: 0 = host, 1 = device |
| req_wide | input | 1 | 1 = 32-bit register, 0 = 16-bit |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address for the command phase |
| req_wdata | input | 32 | Write data, low word sent first |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected request, valid with done |
| rdata | output | 32 | Read result |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_a0 | output | 1 | Port select: 1 = command, 0 = data |
| bus_a1 | output | 1 | Side select: 1 = device, 0 = host |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_data | inout | 16 | Tri-state data bus |

## Verification
The hardest case to reach is a request arriving while an access is already running. It only shows up at the ports as bus cycles that never happen. The bench starts a 32-bit write, confirms busy in the middle of the first gap, presents a device-side command write, and then checks that the write log holds only the three host-side cycles. A bench model of the controller answers reads from the last command word and a per-side word index. This lets the check on read word order also confirm that the command phase reached the correct side. A monitor measures every chip-select gap and strobe width in cycles.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    typedef enum logic [1:0] {
        SG_IDLE  = 2'd0,
        SG_SETUP = 2'd1,
        SG_PULSE = 2'd2,
        SG_HOLD  = 2'd3
    } sg_state_e;

    typedef enum logic [1:0] {
        TP_IDLE = 2'd0,
        TP_XFER = 2'd1,
        TP_GAP  = 2'd2
    } tp_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hcs_gap_timer.sv
module hcs_gap_timer #(
    parameter int GAP_CYC = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(GAP_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == CW'(1));

    initial begin
        AST_GAP_PARAM: assert (GAP_CYC >= 1); // R5
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(GAP_CYC)); // R5

    AST_TIMER_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/hcs_strobe_gen.sv
module hcs_strobe_gen
    import hcs_pkg::*;
#(
    parameter int DW        = 16,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_a0,
    input  logic          in_a1,
    input  logic          in_wr,
    input  logic [DW-1:0] in_wdata,
    input  logic [DW-1:0] din,
    output logic          cs_n,
    output logic          a0,
    output logic          a1,
    output logic          rd_n,
    output logic          wr_n,
    output logic          oe,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] rword,
    output logic          xfer_done
);
    localparam int MAXC = max3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        sg_state_e     st;
        logic [CW-1:0] cnt;
        logic          a0;
        logic          a1;
        logic          wr;
        logic [DW-1:0] wd;
        logic [DW-1:0] rw;
        logic          cs_n;
        logic          rd_n;
        logic          wr_n;
        logic          oe;
    } sg_t;

    sg_t d, q;

    always_comb begin
        d         = q;
        xfer_done = 1'b0;
        case (q.st)
            SG_IDLE: begin
                if (start) begin
                    d.st  = SG_SETUP;
                    d.cnt = '0;
                    d.a0  = in_a0;
                    d.a1  = in_a1;
                    d.wr  = in_wr;
                    d.wd  = in_wdata;
                end
            end
            SG_SETUP: begin
                if (q.cnt == CW'(SETUP_CYC - 1)) begin
                    d.st  = SG_PULSE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SG_PULSE: begin
                if (q.cnt == CW'(PULSE_CYC - 1)) begin
                    d.st  = SG_HOLD;
                    d.cnt = '0;
                    if (!q.wr) begin
                        d.rw = din;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SG_HOLD: begin
                if (q.cnt == CW'(HOLD_CYC - 1)) begin
                    d.st      = SG_IDLE;
                    d.cnt     = '0;
                    xfer_done = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = SG_IDLE;
        endcase
        d.cs_n = (d.st == SG_IDLE);
        d.rd_n = !((d.st == SG_PULSE) && !d.wr);
        d.wr_n = !((d.st == SG_PULSE) && d.wr);
        d.oe   = (d.st == SG_PULSE) && d.wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= SG_IDLE;
            q.cs_n <= 1'b1;
            q.rd_n <= 1'b1;
            q.wr_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n  = q.cs_n;
    assign a0    = q.a0;
    assign a1    = q.a1;
    assign rd_n  = q.rd_n;
    assign wr_n  = q.wr_n;
    assign oe    = q.oe;
    assign dout  = q.wd;
    assign rword = q.rw;

    initial begin
        AST_TIMING_PARAMS: assert (SETUP_CYC >= 1 && PULSE_CYC >= 1 && HOLD_CYC >= 1); // R6
    end

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !cs_n); // R6

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R6

    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (!wr_n && !cs_n)); // R7

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> ($stable(a0) && $stable(a1))); // R2

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start && q.st != SG_IDLE) |-> 1'b0); // R10

endmodule

// File: rtl/hc_reg_seq.sv
module hc_reg_seq
    import hcs_pkg::*;
#(
    parameter int DW            = 16,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int CS_GAP_PS     = 300000,
    parameter int SETUP_CYC     = 1,
    parameter int PULSE_CYC     = 3,
    parameter int HOLD_CYC      = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_direct,
    input  logic            req_cmdport,
    input  logic            req_dev,
    input  logic            req_wide,
    input  logic            req_write,
    input  logic [15:0]     req_addr,
    input  logic [31:0]     req_wdata,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [31:0]     rdata,
    output logic            bus_cs_n,
    output logic            bus_a0,
    output logic            bus_a1,
    output logic            bus_rd_n,
    output logic            bus_wr_n,
    inout  wire  [15:0]     bus_data
);
    localparam int GAP_CYC = ceil_div(CS_GAP_PS, CLK_PERIOD_PS);
    localparam int HW      = $clog2(GAP_CYC + 1);

    typedef struct packed {
        tp_state_e   st;
        logic [1:0]  ph;
        logic [1:0]  last;
        logic        dev;
        logic        wr;
        logic        direct;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        busy;
        logic        done;
        logic        err;
    } tp_t;

    tp_t d, q;

    logic          x_start;
    logic          x_a0;
    logic          x_a1;
    logic          x_wr;
    logic [DW-1:0] x_wdata;
    logic          x_done;
    logic [DW-1:0] x_rword;
    logic          gap_load;
    logic          gap_expire;
    logic          sg_oe;
    logic [DW-1:0] sg_dout;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        x_start  = 1'b0;
        x_a0     = 1'b0;
        x_a1     = q.dev;
        x_wr     = q.wr;
        x_wdata  = q.wdata[DW-1:0];
        gap_load = 1'b0;
        case (q.st)
            TP_IDLE: begin
                if (req_valid) begin
                    if (req_direct && req_cmdport && !req_write) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.st     = TP_XFER;
                        d.busy   = 1'b1;
                        d.dev    = req_dev;
                        d.wr     = req_write;
                        d.direct = req_direct;
                        d.wdata  = req_wdata;
                        d.rdata  = '0;
                        x_start  = 1'b1;
                        x_a1     = req_dev;
                        if (req_direct) begin
                            d.ph    = 2'd1;
                            d.last  = 2'd1;
                            x_a0    = req_cmdport;
                            x_wr    = req_write;
                            x_wdata = req_wdata[DW-1:0];
                        end else begin
                            d.ph    = 2'd0;
                            d.last  = req_wide ? 2'd2 : 2'd1;
                            x_a0    = 1'b1;
                            x_wr    = 1'b1;
                            x_wdata = req_addr;
                        end
                    end
                end
            end
            TP_XFER: begin
                if (x_done) begin
                    if (!q.wr && q.ph != 2'd0) begin
                        if (q.ph == 2'd2) begin
                            d.rdata[31:16] = x_rword;
                        end else begin
                            d.rdata[15:0] = x_rword;
                        end
                    end
                    if (q.ph == q.last) begin
                        d.st   = TP_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.st     = TP_GAP;
                        gap_load = 1'b1;
                    end
                end
            end
            TP_GAP: begin
                if (gap_expire) begin
                    d.st    = TP_XFER;
                    d.ph    = q.ph + 2'd1;
                    x_start = 1'b1;
                    x_a0    = 1'b0;
                    x_a1    = q.dev;
                    x_wr    = q.wr;
                    x_wdata = (q.ph == 2'd1) ? q.wdata[31:16] : q.wdata[15:0];
                end
            end
            default: d.st = TP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= TP_IDLE;
        end else begin
            q <= d;
        end
    end

    hcs_strobe_gen #(
        .DW        (DW),
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (x_start),
        .in_a0     (x_a0),
        .in_a1     (x_a1),
        .in_wr     (x_wr),
        .in_wdata  (x_wdata),
        .din       (bus_data),
        .cs_n      (bus_cs_n),
        .a0        (bus_a0),
        .a1        (bus_a1),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .oe        (sg_oe),
        .dout      (sg_dout),
        .rword     (x_rword),
        .xfer_done (x_done)
    );

    hcs_gap_timer #(
        .GAP_CYC (GAP_CYC)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (gap_load),
        .expire (gap_expire)
    );

    assign bus_data = sg_oe ? sg_dout : {DW{1'bz}};
    assign busy     = q.busy;
    assign done     = q.done;
    assign err      = q.err;
    assign rdata    = q.rdata;

    // Count of cycles chip select has been seen high, saturating at the gap
    logic [HW-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (!bus_cs_n) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q < HW'(GAP_CYC)) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_cs_n) && q.busy && !q.direct && q.ph != 2'd0)
            |-> (hi_cnt_q == HW'(GAP_CYC))); // R5

    AST_CMD_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_a0) |-> bus_rd_n); // R9

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (bus_cs_n && done && !busy)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_BUS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> busy); // R10

    AST_SIDE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && q.busy) |-> (bus_a1 == q.dev)); // R2

endmodule

// File: tb/tb_hc_reg_seq.sv
module tb_hc_reg_seq;

    localparam int PULSE  = 3;
    localparam int GAPX   = (300 * 1000 + 8000 - 1) / 8000;  // 38 cycles
    localparam int NVEC   = 9;

    // {direct, cmdport, dev, wide, write, addr[15:0], wdata[31:0]}
    localparam logic [52:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0024, 32'h0000_1234},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0031, 32'hCAFE_BEEF},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0028, 32'h0000_0000},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0042, 32'h0000_0000},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 32'h0000_0017},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h0000_0000},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 32'h0000_0000},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 32'h0000_00AB},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00FF, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_direct = 1'b0;
    logic        req_cmdport = 1'b0;
    logic        req_dev = 1'b0;
    logic        req_wide = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, err;
    logic [31:0] rdata;
    logic        bus_cs_n, bus_a0, bus_a1, bus_rd_n, bus_wr_n;
    wire  [15:0] bus_data;

    always #4 clk = ~clk;

    hc_reg_seq dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_direct (req_direct), .req_cmdport (req_cmdport),
        .req_dev (req_dev), .req_wide (req_wide), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .busy (busy), .done (done), .err (err), .rdata (rdata),
        .bus_cs_n (bus_cs_n), .bus_a0 (bus_a0), .bus_a1 (bus_a1),
        .bus_rd_n (bus_rd_n), .bus_wr_n (bus_wr_n), .bus_data (bus_data)
    );

    // ---------------- controller model ----------------
    logic [15:0] cmd_last [2];
    int          widx [2];

    function automatic logic [15:0] mrd(input logic [15:0] c, input int i, input logic side);
        return c ^ (16'(i) * 16'h1111) ^ (side ? 16'h0F0F : 16'h0000);
    endfunction

    logic [15:0] model_val;
    assign model_val = mrd(cmd_last[bus_a1], widx[bus_a1], bus_a1);
    assign bus_data  = (!bus_cs_n && !bus_rd_n) ? model_val : 16'hzzzz;

    // ---------------- monitor ----------------
    logic        log_a0 [8];
    logic        log_a1 [8];
    logic [15:0] log_d  [8];
    int          n_wr, n_rd, viol, gap_min, hi_run, wr_run, rd_run;
    logic        seen_low, prev_cs_hi;
    logic        h_a0, h_a1, r_a1;
    logic [15:0] h_d;

    initial begin
        cmd_last[0] = '0; cmd_last[1] = '0; widx[0] = 0; widx[1] = 0;
        n_wr = 0; n_rd = 0; viol = 0; gap_min = 9999; hi_run = 0;
        wr_run = 0; rd_run = 0; seen_low = 1'b0; prev_cs_hi = 1'b1;
        h_a0 = 1'b0; h_a1 = 1'b0; r_a1 = 1'b0; h_d = '0;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if ((!bus_rd_n || !bus_wr_n) && bus_cs_n) viol = viol + 1;
            if (!bus_wr_n) begin
                wr_run = wr_run + 1;
                h_d = bus_data; h_a0 = bus_a0; h_a1 = bus_a1;
            end else if (wr_run != 0) begin
                if (wr_run != PULSE) viol = viol + 1;
                if (n_wr < 8) begin
                    log_a0[n_wr] = h_a0; log_a1[n_wr] = h_a1; log_d[n_wr] = h_d;
                end
                n_wr = n_wr + 1;
                if (h_a0) begin
                    cmd_last[h_a1] = h_d; widx[h_a1] = 0;
                end else begin
                    widx[h_a1] = widx[h_a1] + 1;
                end
                wr_run = 0;
            end
            if (!bus_rd_n) begin
                rd_run = rd_run + 1; r_a1 = bus_a1;
            end else if (rd_run != 0) begin
                if (rd_run != PULSE) viol = viol + 1;
                n_rd = n_rd + 1;
                widx[r_a1] = widx[r_a1] + 1;
                rd_run = 0;
            end
            if (bus_cs_n) begin
                hi_run = hi_run + 1;
            end else begin
                if (prev_cs_hi && seen_low && hi_run < gap_min) gap_min = hi_run;
                seen_low = 1'b1;
                hi_run = 0;
            end
            prev_cs_hi = bus_cs_n;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    int lat;
    logic got_err;
    logic [31:0] got_rd;

    task automatic clear_mon();
        n_wr = 0; n_rd = 0; gap_min = 9999; seen_low = 1'b0; hi_run = 0;
    endtask

    task automatic issue(input logic [52:0] v);
        {req_direct, req_cmdport, req_dev, req_wide, req_write, req_addr, req_wdata} = v;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        lat = 1;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat = lat + 1;
        end
        if (!done) chk(1'b0, "watchdog on done", 0, 1);
        got_err = err;
        got_rd  = rdata;
        @(negedge clk);
        chk(!done, "R11 done lasts one cycle", 64'(done), 0);
    endtask

    initial begin
        #(8ns * 200000);
        chk(1'b0, "global watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_cs_n && bus_rd_n && bus_wr_n, "R11 reset bus idle",
            64'({bus_cs_n, bus_rd_n, bus_wr_n}), 64'h7);
        chk(!busy && !done && !err, "R11 reset flags", 64'({busy, done, err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            logic        dr, cp, dv, wd, wr, bad;
            logic [15:0] ad;
            logic [31:0] wv, exp_rd;
            int          nw, exp_wr, exp_rdn;
            {dr, cp, dv, wd, wr, ad, wv} = VEC[k];
            bad = dr && cp && !wr;
            nw  = wd ? 2 : 1;
            if (dr) begin
                exp_rd  = {16'h0, mrd(cmd_last[dv], widx[dv], dv)};
                exp_wr  = bad ? 0 : (wr ? 1 : 0);
                exp_rdn = bad ? 0 : (wr ? 0 : 1);
            end else begin
                exp_rd  = wd ? {mrd(ad, 1, dv), mrd(ad, 0, dv)} : {16'h0, mrd(ad, 0, dv)};
                exp_wr  = 1 + (wr ? nw : 0);
                exp_rdn = wr ? 0 : nw;
            end
            clear_mon();
            issue(VEC[k]);
            wait_done();
            repeat (2) @(negedge clk);

            chk(got_err == bad, $sformatf("R9 err flag vec %0d", k), 64'(got_err), 64'(bad));
            if (bad) chk(lat == 1, $sformatf("R9 reject latency vec %0d", k), 64'(lat), 1);
            chk(n_wr == exp_wr, $sformatf("R3 R4 R12 write cycles vec %0d", k), 64'(n_wr), 64'(exp_wr));
            chk(n_rd == exp_rdn, $sformatf("R3 R4 R12 read cycles vec %0d", k), 64'(n_rd), 64'(exp_rdn));
            if (!dr) begin
                chk(log_a0[0] == 1'b1 && log_a1[0] == dv && log_d[0] == ad,
                    $sformatf("R1 R2 command cycle vec %0d", k),
                    64'({log_a0[0], log_a1[0], log_d[0]}), 64'({1'b1, dv, ad}));
                chk(gap_min == GAPX, $sformatf("R5 cs gap vec %0d", k), 64'(gap_min), 64'(GAPX));
                if (wr) begin
                    chk(log_a0[1] == 1'b0 && log_a1[1] == dv && log_d[1] == wv[15:0],
                        $sformatf("R3 R4 first data word vec %0d", k),
                        64'({log_a0[1], log_a1[1], log_d[1]}), 64'({1'b0, dv, wv[15:0]}));
                    if (wd) chk(log_d[2] == wv[31:16] && log_a0[2] == 1'b0,
                        $sformatf("R4 second data word vec %0d", k), 64'(log_d[2]), 64'(wv[31:16]));
                end
            end else if (!bad && wr) begin
                chk(log_a0[0] == cp && log_a1[0] == dv && log_d[0] == wv[15:0],
                    $sformatf("R12 direct port cycle vec %0d", k),
                    64'({log_a0[0], log_a1[0], log_d[0]}), 64'({cp, dv, wv[15:0]}));
            end
            if (!wr && !bad)
                chk(got_rd == exp_rd, $sformatf("R8 read data vec %0d", k), 64'(got_rd), 64'(exp_rd));
        end

        // R10: a request arriving while busy is dropped
        clear_mon();
        issue({1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0055, 32'h1111_2222});
        repeat (8) @(negedge clk);
        chk(busy == 1'b1, "R10 busy during gap", 64'(busy), 1);
        issue({1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, 32'h0000_0999});
        wait_done();
        repeat (2) @(negedge clk);
        chk(n_wr == 3, "R10 ignored request adds no cycle", 64'(n_wr), 3);
        chk(log_a1[0] == 1'b0 && log_a1[1] == 1'b0 && log_a1[2] == 1'b0,
            "R10 R2 only host side touched", 64'({log_a1[0], log_a1[1], log_a1[2]}), 0);
        chk(log_d[1] == 16'h2222 && log_d[2] == 16'h1111, "R4 word order",
            64'({log_d[1], log_d[2]}), 64'h2222_1111);
        chk(!busy, "R10 busy clears after done", 64'(busy), 0);

        chk(viol == 0, "R6 strobe width and chip select", 64'(viol), 0);
        finish_up();
    end

endmodule